// File: doc/BRIEF.md
# Multiplexed External Bus Word Fetch Sequencer

This block fetches one 16-bit word from external memory in each instruction cycle over a shared address/data bus. Every instruction cycle lasts four system clocks, named Q1 to Q4. The phase counter runs freely. At the clock edge that opens Q1 the block samples a fetch request and a 21-bit byte program counter. If a request is present, the block drives the word address in Q1 and pulses the address strobe so that an external transparent latch can hold the low 16 bits. It then releases the bus and pulls the active-low read enable down for Q3 and Q4. It captures the returned word at the edge where the read enable goes high again.

The program counter is a byte address. Bits 16:1 go out on the shared lines and bits 20:17 go out on four dedicated upper lines. Bit 0 appears on the byte-select output during Q3. The external latch and the memory are not part of the block. The block only reads; it has no write or byte-enable strobes.

Top module: `xbf_fetch_seq`

## Requirements
- R1: After reset the first clock is Q1, and the phases then advance Q1, Q2, Q3, Q4, Q1, ... with one phase per clock, with or without requests.
- R2: `fetch_req` and `pc` are sampled only at the clock edge that starts Q1. Changes to them during Q1, Q2 or Q3 have no effect on the cycle in progress.
- R3: During Q1 of a fetch, `ale`=1, `ad_oe`=1, `ad_out`=`pc[16:1]` and `addr_hi`=`pc[20:17]`. `ale` is 0 in Q2, Q3 and Q4.
- R4: `ad_oe` is 0 in Q2 to Q4 and in idle cycles. During a fetch, `ad_out` and `addr_hi` keep the sampled address through all four phases, so the address is still present when `ale` falls.
- R5: `oe_n` is 0 in Q3 and Q4 of a fetch and 1 at all other times.
- R6: `ba0` equals `pc[0]` during Q3 of a fetch and is 0 at all other times.
- R7: `word_q` takes the `ad_in` value present during Q4, at the edge that ends Q4 (where `oe_n` rises). The value on `ad_in` during Q3 does not matter.
- R8: `word_valid` is 1 for exactly the one clock after that edge, which is the next Q1. At all other times it is 0, and `word_q` holds its value.
- R9: In a cycle with no request, `ale`=0, `oe_n`=1, `ba0`=0 and `ad_oe`=0 in all four phases, and `word_q` does not change.
- R10: While reset is low, `ale`=0, `oe_n`=1, `ba0`=0, `ad_oe`=0, `word_valid`=0 and `word_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Request one word fetch in the next instruction cycle |
| pc | input | 21 | Byte program counter for the fetch |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Value read back from the shared lines |
| addr_hi | output | 4 | Upper address lines (pc bits 20:17) |
| ale | output | 1 | Address strobe; external latch closes on its falling edge |
| oe_n | output | 1 | Active-low read enable to memory |
| ba0 | output | 1 | Byte-select bit, valid in Q3 |
| word_q | output | 16 | Last captured word |
| word_valid | output | 1 | One-clock pulse after each capture |

## Verification
The bench models the external latch on the falling edge of `ale` and checks that the held address matches the requested counter. A design that released the address too early would leave the wrong address in the latch. During Q3 the bench drives the inverse of the correct memory word and puts the correct word on the bus only in Q4, so a design that captured one phase early would store the inverted word. After each Q1 the bench changes `pc` and `fetch_req` to random values, which exposes a design that samples them at the wrong edge. Idle cycles mixed among fetches show whether strobes leak out or `word_q` changes when no request is present. Odd and even counters, including all-ones and zero, show whether `ba0` is placed in the wrong phase or does not follow bit 0.

// File: rtl/xbf_pkg.sv
package xbf_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } xbf_phase_t;

endpackage

// File: rtl/xbf_phase.sv
module xbf_phase
    import xbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output xbf_phase_t ph_q,
    output xbf_phase_t ph_nxt
);

    xbf_phase_t ph_d;

    always_comb begin
        ph_d = xbf_phase_t'(ph_q + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_Q1;
        else        ph_q <= ph_d;
    end

    assign ph_nxt = rst_n ? ph_d : PH_Q1;

    // R1: one phase step per clock once out of reset
    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ph_q == xbf_phase_t'($past(ph_q) + 2'd1)));

endmodule

// File: rtl/xbf_capture.sv
module xbf_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] word_q,
    output logic              valid_q
);

    logic [DATA_W-1:0] word_d;
    logic              valid_d;

    always_comb begin
        word_d  = word_q;
        valid_d = 1'b0;
        if (cap_en) begin
            word_d  = din;
            valid_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            word_q  <= word_d;
            valid_q <= valid_d;
        end
    end

    // R8: the valid flag is a single-clock pulse
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R8: the word holds whenever no capture took place
    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && $past(rst_n)) |-> $stable(word_q));

endmodule

// File: rtl/xbf_fetch_seq.sv
module xbf_fetch_seq
    import xbf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PC_W   = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [PC_W-1:0]   pc,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [PC_W-DATA_W-2:0] addr_hi,
    output logic              ale,
    output logic              oe_n,
    output logic              ba0,
    output logic [DATA_W-1:0] word_q,
    output logic              word_valid
);

    localparam int HI_W = PC_W - DATA_W - 1;

    typedef struct packed {
        logic            busy;
        logic [PC_W-1:0] addr;
        logic            ale;
        logic            oe_n;
        logic            ba0;
        logic            ad_oe;
    } seq_st_t;

    xbf_phase_t ph_q;
    xbf_phase_t ph_nxt;
    seq_st_t    st_d;
    seq_st_t    st_q;
    logic       cap_en;

    xbf_phase i_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_q   (ph_q),
        .ph_nxt (ph_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (ph_q == PH_Q4) begin
            st_d.busy = fetch_req;
            if (fetch_req) st_d.addr = pc;
        end
        st_d.ale   = st_d.busy && (ph_nxt == PH_Q1);
        st_d.ad_oe = st_d.busy && (ph_nxt == PH_Q1);
        st_d.oe_n  = !(st_d.busy && ((ph_nxt == PH_Q3) || (ph_nxt == PH_Q4)));
        st_d.ba0   = st_d.busy && (ph_nxt == PH_Q3) && st_d.addr[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.oe_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_en = st_q.busy && (ph_q == PH_Q4);

    xbf_capture #(.DATA_W(DATA_W)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .din     (ad_in),
        .word_q  (word_q),
        .valid_q (word_valid)
    );

    assign ad_out  = st_q.addr[DATA_W:1];
    assign addr_hi = st_q.addr[PC_W-1:DATA_W+1];
    assign ale     = st_q.ale;
    assign ad_oe   = st_q.ad_oe;
    assign oe_n    = st_q.oe_n;
    assign ba0     = st_q.ba0;

    // R3: the strobe only ever rises while the block drives the bus
    p_ale_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    // R4: address lines unchanged at the edge where the strobe falls
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> ($stable(ad_out) && $stable(addr_hi)));

    // R5: never read enable while driving the shared lines
    p_oe_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ad_oe);

    // R6: byte select only in the first read-enable clock
    p_ba0_q3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ba0 |-> (!oe_n && $past(oe_n)));

    // R8: each end of a read enable yields a valid pulse
    p_valid_on_oe_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> word_valid);

    // R5: read enable lasts exactly two clocks
    p_oe_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe_n)) |=> !oe_n);

endmodule

// File: tb/test_xbf_fetch_seq.sv
module test_xbf_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_req;
    logic [20:0] pc;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in;
    logic [3:0]  addr_hi;
    logic        ale;
    logic        oe_n;
    logic        ba0;
    logic [15:0] word_q;
    logic        word_valid;

    int          checks = 0;
    int          errors = 0;
    logic [19:0] lat_addr;
    logic [15:0] exp_word = 16'h0;
    logic        prev_req = 1'b0;

    always #10 clk = ~clk;

    xbf_fetch_seq i_xbf_fetch_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .pc         (pc),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ad_in      (ad_in),
        .addr_hi    (addr_hi),
        .ale        (ale),
        .oe_n       (oe_n),
        .ba0        (ba0),
        .word_q     (word_q),
        .word_valid (word_valid)
    );

    always @(negedge ale) lat_addr = {addr_hi, ad_out};

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        logic [31:0] t;
        t = {12'h0, a} * 32'd40503;
        return t[15:0] ^ {a[19:16], a[11:0]} ^ 16'h3C5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_icycle(input bit req, input logic [20:0] a);
        fetch_req = req;
        pc        = a;
        @(negedge clk); // Q1
        chk(ale == req, "R3 ale in Q1", 32'(ale), 32'(req));
        chk(ad_oe == req, "R3 ad_oe in Q1", 32'(ad_oe), 32'(req));
        chk(oe_n == 1'b1, "R5 oe_n in Q1", 32'(oe_n), 1);
        chk(ba0 == 1'b0, "R6 ba0 in Q1", 32'(ba0), 0);
        chk(word_valid == prev_req, "R8 valid in Q1", 32'(word_valid), 32'(prev_req));
        chk(word_q == exp_word, "R7 word after capture", 32'(word_q), 32'(exp_word));
        if (req) begin
            chk(ad_out == a[16:1], "R3 ad_out", 32'(ad_out), 32'(a[16:1]));
            chk(addr_hi == a[20:17], "R3 addr_hi", 32'(addr_hi), 32'(a[20:17]));
        end
        fetch_req = 1'($urandom);
        pc        = 21'($urandom);
        ad_in     = 16'($urandom);
        @(negedge clk); // Q2
        chk(ale == 1'b0, "R3 ale in Q2", 32'(ale), 0);
        chk(ad_oe == 1'b0, "R4 ad_oe in Q2", 32'(ad_oe), 0);
        chk(oe_n == 1'b1, "R5 oe_n in Q2", 32'(oe_n), 1);
        chk(word_valid == 1'b0, "R8 valid in Q2", 32'(word_valid), 0);
        if (req) begin
            chk(lat_addr == a[20:1], "R4 latched address", 32'(lat_addr), 32'(a[20:1]));
            chk(ad_out == a[16:1], "R2 R4 ad_out hold Q2", 32'(ad_out), 32'(a[16:1]));
        end
        fetch_req = 1'($urandom);
        pc        = 21'($urandom);
        ad_in     = ~mem_word(a[20:1]);
        @(negedge clk); // Q3
        chk(oe_n == !req, "R5 oe_n in Q3", 32'(oe_n), 32'(!req));
        chk(ba0 == (req & a[0]), "R6 ba0 in Q3", 32'(ba0), 32'(req & a[0]));
        chk(ad_oe == 1'b0, "R4 ad_oe in Q3", 32'(ad_oe), 0);
        chk(ale == 1'b0, "R9 ale in Q3", 32'(ale), 0);
        if (req)
            chk(addr_hi == a[20:17], "R2 R4 addr_hi hold Q3", 32'(addr_hi), 32'(a[20:17]));
        ad_in = req ? mem_word(a[20:1]) : 16'($urandom);
        @(negedge clk); // Q4
        chk(oe_n == !req, "R5 oe_n in Q4", 32'(oe_n), 32'(!req));
        chk(ba0 == 1'b0, "R6 ba0 in Q4", 32'(ba0), 0);
        chk(word_q == exp_word, "R9 word held in Q4", 32'(word_q), 32'(exp_word));
        chk(ad_oe == 1'b0, "R4 ad_oe in Q4", 32'(ad_oe), 0);
        if (req) exp_word = mem_word(a[20:1]);
        prev_req = req;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n     = 1'b0;
        fetch_req = 1'b1;
        pc        = 21'h1ABCD;
        ad_in     = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ale == 1'b0 && ad_oe == 1'b0, "R10 reset strobes", {ale, ad_oe}, 0);
        chk(oe_n == 1'b1 && ba0 == 1'b0, "R10 reset oe_n/ba0", {oe_n, ba0}, 2);
        chk(word_valid == 1'b0 && word_q == 16'h0, "R10 reset word", 32'(word_q), 0);
        rst_n = 1'b1;
        // first clock after reset is Q1 with no fetch (R1)
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(ale == 1'b0 && oe_n == 1'b1, "R1 R9 idle after reset", {ale, oe_n}, 1);
        end
        // directed corners
        do_icycle(1'b1, 21'h1FFFFF);
        do_icycle(1'b1, 21'h000000);
        do_icycle(1'b0, 21'h0F0F0F);
        do_icycle(1'b1, 21'h000001);
        do_icycle(1'b0, 21'h1FFFFF);
        do_icycle(1'b0, 21'h000000);
        do_icycle(1'b1, 21'h12345A);
        do_icycle(1'b1, 21'h12345B);
        // random mix
        for (int i = 0; i < 400; i++) begin
            do_icycle(($urandom % 4) != 0, 21'($urandom));
        end
        do_icycle(1'b0, 21'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule